// File: doc/BRIEF.md
# Register-Programmable PWM Generator

This block produces one pulse-width-modulated output. Software controls it through two 32-bit registers on a simple write/read port. The input clock first goes through a prescaler that divides it by (1 + scale). Each prescaled tick advances a period counter, which wraps after (1 + depth) ticks. The output is high for the first `width` counts of every period and low for the rest. A width of zero keeps the output low. A width of (1 + depth) or more keeps it high.

New width, scale and depth values are written into staging registers. The running generator copies them only at a period boundary, so a write never produces a cut-short or merged period.

Clearing the enable bit drives the output low at once and holds both counters at zero. Setting the enable bit starts a fresh period on the same clock edge as the write.

A build-time parameter selects a legacy layout. In that layout a single register holds the enable, an 8-bit width, a 13-bit scale and a force-full-duty bit, and the depth is fixed at 256 counts.

Top module: `pwmgen_top`

## Requirements
- R1: Wide layout (LEGACY=0). Address 0 holds the pulse width in bits 31:16 and the scale in bits 15:0. Address 1 holds the enable in bit 31 (1 = running) and the depth in bits 30:15.
- R2: A read returns the last value written to the addressed register. Bits that have no meaning in the active layout read as zero: bits 14:0 of address 1 in the wide layout, and bits 30:25 and 15:13 of address 0 in the legacy layout. In the legacy layout, address 1 always reads zero and a write to it has no effect on the output.
- R3: While enabled, one period lasts (1 + scale) × (1 + depth) clock cycles.
- R4: The output is high for the first width × (1 + scale) cycles of each period and low for the remainder. A width of 0 keeps the output low.
- R5: A width greater than or equal to (1 + depth) keeps the output high for the whole period.
- R6: While disabled, the output is low and the prescaler and period counter are held at zero. The clock edge that writes enable = 1 starts a period. In the first cycle after that edge, the output is high if the width is nonzero.
- R7: Width, scale and depth written while running take effect only at the start of the next period. The period in progress completes with the old values.
- R8: Legacy layout (LEGACY=1). Address 0 holds the enable in bit 31, the width in bits 23:16 and the scale in bits 12:0. The period is 256 counts.
- R9: In the legacy layout, bit 24 of address 0 forces the output high for the whole period, whatever the width field holds.
- R10: After reset, both registers read zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select (0 or 1) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the register selected by addr_i |
| pwm_o | output | 1 | Modulated output |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a running period. It has to be shown that the period in progress still finishes with the old width or depth, and that the new values appear exactly on the following boundary. The stimulus enables the generator with a known depth and counts clock cycles from the enabling edge. It then writes a new width, and later a new depth, at chosen cycle offsets inside a period. The bench counts the high cycles of the remainder of that period and of the next full period, and compares each count with a value worked out by hand.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;
    parameter int unsigned CNT_W = 16;
    localparam int unsigned REG_W = 32;
    localparam int unsigned LEG_DUTY_W = 8;
    localparam int unsigned LEG_SCALE_W = 13;
    localparam int unsigned LEG_DEPTH = 255;

    localparam logic [REG_W-1:0] WIDE_R0_MASK = 32'hFFFF_FFFF;
    localparam logic [REG_W-1:0] WIDE_R1_MASK = 32'hFFFF_8000;
    localparam logic [REG_W-1:0] LEG_R0_MASK  = 32'h81FF_1FFF;
    localparam logic [REG_W-1:0] LEG_R1_MASK  = 32'h0000_0000;

    typedef struct packed {
        logic [CNT_W-1:0] width;
        logic [CNT_W-1:0] scale;
        logic [CNT_W-1:0] depth;
        logic             force_full;
    } cfg_t;
endpackage

// File: rtl/pwmgen_regs.sv
module pwmgen_regs
    import pwmgen_pkg::*;
#(
    parameter bit LEGACY = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic             addr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    output cfg_t             prog_o,
    output logic             en_o
);
    localparam logic [REG_W-1:0] R0_MASK = LEGACY ? LEG_R0_MASK : WIDE_R0_MASK;
    localparam logic [REG_W-1:0] R1_MASK = LEGACY ? LEG_R1_MASK : WIDE_R1_MASK;

    typedef struct packed {
        logic [REG_W-1:0] r0;
        logic [REG_W-1:0] r1;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i) begin
            if (addr_i) s_d.r1 = wdata_i & R1_MASK;
            else        s_d.r0 = wdata_i & R0_MASK;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rdata_o = addr_i ? s_q.r1 : s_q.r0;

    // Staged configuration is taken from the next register value so that a
    // write on the enabling edge is already visible to the first period.
    generate
        if (LEGACY) begin : g_legacy
            logic unused_leg;
            assign unused_leg = ^{s_d.r1, s_q.r1, s_d.r0[30:25], s_d.r0[15:13]};
            always_comb begin
                prog_o.width      = {{(CNT_W-LEG_DUTY_W){1'b0}}, s_d.r0[23:16]};
                prog_o.scale      = {{(CNT_W-LEG_SCALE_W){1'b0}}, s_d.r0[LEG_SCALE_W-1:0]};
                prog_o.depth      = CNT_W'(LEG_DEPTH);
                prog_o.force_full = s_d.r0[24];
            end
            assign en_o = s_q.r0[REG_W-1];
        end else begin : g_wide
            logic unused_wide;
            assign unused_wide = ^{s_d.r1[REG_W-CNT_W-2:0], s_d.r1[REG_W-1], s_q.r0, s_q.r1[REG_W-2:0]};
            always_comb begin
                prog_o.width      = s_d.r0[REG_W-1 -: CNT_W];
                prog_o.scale      = s_d.r0[CNT_W-1:0];
                prog_o.depth      = s_d.r1[REG_W-2 -: CNT_W];
                prog_o.force_full = 1'b0;
            end
            assign en_o = s_q.r1[REG_W-1];
        end
    endgenerate
endmodule

// File: rtl/pwmgen_prescale.sv
module pwmgen_prescale
    import pwmgen_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CNT_W-1:0] scale_i,
    output logic             tick_o,
    output logic [CNT_W-1:0] psc_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } psc_t;

    psc_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en_i)                  s_d.cnt = '0;
        else if (s_q.cnt == scale_i) s_d.cnt = '0;
        else                        s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign tick_o = en_i && (s_q.cnt == scale_i);
    assign psc_o  = s_q.cnt;
endmodule

// File: rtl/pwmgen_period.sv
module pwmgen_period
    import pwmgen_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             tick_i,
    input  cfg_t             prog_i,
    output cfg_t             act_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pwm_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        cfg_t             act;
    } per_t;

    per_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en_i) begin
            s_d.cnt = '0;
            s_d.act = prog_i;
        end else if (tick_i) begin
            if (s_q.cnt == s_q.act.depth) begin
                s_d.cnt = '0;
                s_d.act = prog_i;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign act_o = s_q.act;
    assign cnt_o = s_q.cnt;
    assign pwm_o = en_i && (s_q.act.force_full || (s_q.cnt < s_q.act.width));
endmodule

// File: rtl/pwmgen_top.sv
module pwmgen_top
    import pwmgen_pkg::*;
#(
    parameter bit LEGACY = 1'b0
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        we_i,
    input  logic        addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        pwm_o
);
    cfg_t             prog_w;
    cfg_t             act_w;
    logic             en_w;
    logic             tick_w;
    logic [CNT_W-1:0] psc_w;
    logic [CNT_W-1:0] cnt_w;

    pwmgen_regs #(.LEGACY(LEGACY)) regs_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .prog_o  (prog_w),
        .en_o    (en_w)
    );

    pwmgen_prescale psc_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_w),
        .scale_i (act_w.scale),
        .tick_o  (tick_w),
        .psc_o   (psc_w)
    );

    pwmgen_period per_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_w),
        .tick_i (tick_w),
        .prog_i (prog_w),
        .act_o  (act_w),
        .cnt_o  (cnt_w),
        .pwm_o  (pwm_o)
    );
endmodule

// File: rtl/pwmgen_chk.sv
module pwmgen_chk
    import pwmgen_pkg::*;
#(
    parameter bit LEGACY = 1'b0
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             pwm_o,
    input logic             en_q,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] psc,
    input cfg_t             act
);
    logic boundary;
    assign boundary = tick && (cnt == act.depth);

    AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_q |-> !pwm_o); // R6

    AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_q |=> (cnt == '0 && psc == '0)); // R6

    AST_ZERO_WIDTH_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_q && act.width == '0 && !act.force_full) |-> !pwm_o); // R4

    AST_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_q && act.width > act.depth) |-> pwm_o); // R5

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_q |-> (cnt <= act.depth && psc <= act.scale)); // R3

    AST_SHADOW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_q && !boundary) |=> (!en_q || $stable(act))); // R7

    AST_LEG_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (LEGACY && en_q && act.force_full) |-> pwm_o); // R9

    AST_LEG_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (LEGACY && en_q) |-> (act.depth == CNT_W'(LEG_DEPTH))); // R8
endmodule

bind pwmgen_top pwmgen_chk #(.LEGACY(LEGACY)) chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pwm_o  (pwm_o),
    .en_q   (en_w),
    .tick   (tick_w),
    .cnt    (cnt_w),
    .psc    (psc_w),
    .act    (act_w)
);

// File: tb/pwmgen_top_tb_top.sv
module pwmgen_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_w = 1'b0;
    logic        we_l = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_w, rdata_l;
    logic        pwm_w, pwm_l;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5ns clk = ~clk;

    pwmgen_top #(.LEGACY(1'b0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .we_i(we_w), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata_w), .pwm_o(pwm_w)
    );

    pwmgen_top #(.LEGACY(1'b1)) dut_leg_i (
        .clk_i(clk), .rst_ni(rst_n), .we_i(we_l), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata_l), .pwm_o(pwm_l)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge and the task
    // returns at the negedge right after it (cycle index 0 after the write).
    task automatic wr(input bit leg, input bit a, input logic [31:0] d);
        we_w = !leg; we_l = leg; addr = a; wdata = d;
        @(negedge clk);
        we_w = 1'b0; we_l = 1'b0;
    endtask

    task automatic rd(input bit leg, input bit a, output logic [31:0] d);
        addr = a;
        #1ns;
        d = leg ? rdata_l : rdata_w;
    endtask

    task automatic count_hi(input bit leg, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            hi += leg ? int'(pwm_l) : int'(pwm_w);
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] r1_wide(input bit en, input int depth);
        return {en, 31'(depth) << 15};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(0, 0, d); chk("R10 wide reg0", d, 32'h0);
        rd(0, 1, d); chk("R10 wide reg1", d, 32'h0);
        rd(1, 0, d); chk("R10 legacy reg0", d, 32'h0);
        chk("R10 pwm low", {30'b0, pwm_w, pwm_l}, 32'h0);
    endtask

    task automatic t_basic();
        int hi;
        wr(0, 0, {16'd3, 16'd1});
        chk("R6 staged while off stays low", {31'b0, pwm_w}, 32'h0);
        wr(0, 1, r1_wide(1, 7));
        chk("R6 first cycle high", {31'b0, pwm_w}, 32'h1);
        count_hi(0, 15, hi);
        chk("R4 high cycles width3 scale1", 32'(hi), 32'd6);
        chk("R3 last cycle of period low", {31'b0, pwm_w}, 32'h0);
        @(negedge clk);
        chk("R3 next period at cycle 16", {31'b0, pwm_w}, 32'h1);
        wr(0, 1, r1_wide(0, 7));
        count_hi(0, 20, hi);
        chk("R6 disabled low", 32'(hi), 32'd0);
    endtask

    task automatic t_scale();
        int hi;
        wr(0, 0, {16'd1, 16'd4});
        wr(0, 1, r1_wide(1, 3));
        count_hi(0, 5, hi);
        chk("R4 one count lasts scale+1 cycles", 32'(hi), 32'd5);
        count_hi(0, 15, hi);
        chk("R4 rest of period low", 32'(hi), 32'd0);
        chk("R3 period 20 cycles", {31'b0, pwm_w}, 32'h1);
        wr(0, 1, r1_wide(0, 3));
    endtask

    task automatic t_zero();
        int hi;
        wr(0, 0, {16'd0, 16'd0});
        wr(0, 1, r1_wide(1, 5));
        count_hi(0, 30, hi);
        chk("R4 width zero always low", 32'(hi), 32'd0);
        wr(0, 1, r1_wide(0, 5));
    endtask

    task automatic t_full();
        int hi;
        wr(0, 0, {16'd8, 16'd0});
        wr(0, 1, r1_wide(1, 7));
        count_hi(0, 24, hi);
        chk("R5 width equal depth+1", 32'(hi), 32'd24);
        wr(0, 1, r1_wide(0, 7));
        wr(0, 0, {16'd1000, 16'd0});
        wr(0, 1, r1_wide(1, 7));
        count_hi(0, 24, hi);
        chk("R5 width above depth+1", 32'(hi), 32'd24);
        wr(0, 1, r1_wide(0, 7));
    endtask

    task automatic t_shadow();
        int hi;
        wr(0, 0, {16'd3, 16'd0});
        wr(0, 1, r1_wide(1, 9));
        count_hi(0, 5, hi);
        chk("R7 head of period", 32'(hi), 32'd3);
        wr(0, 0, {16'd7, 16'd0});          // lands at edge 6
        count_hi(0, 4, hi);
        chk("R7 old width kept to period end", 32'(hi), 32'd0);
        count_hi(0, 10, hi);
        chk("R7 new width next period", 32'(hi), 32'd7);
        wr(0, 1, r1_wide(1, 4));           // lands at edge 21
        count_hi(0, 9, hi);
        chk("R7 old depth kept to period end", 32'(hi), 32'd6);
        count_hi(0, 10, hi);
        chk("R7 new depth makes width7 full", 32'(hi), 32'd10);
        wr(0, 1, r1_wide(0, 4));
        chk("R6 disable drops output at once", {31'b0, pwm_w}, 32'h0);
        wr(0, 1, r1_wide(1, 4));
        chk("R6 restart high in first cycle", {31'b0, pwm_w}, 32'h1);
        wr(0, 1, r1_wide(0, 4));
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(0, 0, 32'hABCD_1234);
        rd(0, 0, d); chk("R2 wide reg0 readback", d, 32'hABCD_1234);
        wr(0, 1, 32'h7FFF_FFFF);
        rd(0, 1, d); chk("R2 wide reg1 low bits zero", d, 32'h7FFF_8000);
        rd(0, 0, d); chk("R1 reg1 write leaves reg0", d, 32'hABCD_1234);
        wr(0, 1, 32'h0);
    endtask

    task automatic t_legacy();
        int hi;
        logic [31:0] d;
        wr(1, 0, 32'h8040_0000);
        count_hi(1, 256, hi);
        chk("R8 legacy width64 of 256", 32'(hi), 32'd64);
        chk("R8 legacy period 256", {31'b0, pwm_l}, 32'h1);
        wr(1, 0, 32'h0);
        wr(1, 0, 32'h8100_0000);
        count_hi(1, 512, hi);
        chk("R9 force with width0", 32'(hi), 32'd512);
        wr(1, 0, 32'h0);
        wr(1, 0, 32'h8105_0001);
        count_hi(1, 600, hi);
        chk("R9 force ignores width field", 32'(hi), 32'd600);
        wr(1, 0, 32'h0);
        wr(1, 1, 32'hFFFF_FFFF);
        rd(1, 1, d); chk("R2 legacy reg1 reads zero", d, 32'h0);
        count_hi(1, 10, hi);
        chk("R2 legacy reg1 write no effect", 32'(hi), 32'd0);
        wr(1, 0, 32'hFFFF_FFFF);
        rd(1, 0, d); chk("R2 legacy reg0 unused bits zero", d, 32'h81FF_1FFF);
        wr(1, 0, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_scale();
        t_zero();
        t_full();
        t_shadow();
        t_readback();
        t_legacy();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule